// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit carries out one multi-register load or store as a series of single-word memory accesses. A caller gives it a base address, a 16-bit mask of selected registers, an addressing mode, a load/store select and a writeback flag, and raises a one-cycle start. The sequencer counts the selected registers and works out the lowest address of the block. It then presents one request per selected register on a request/acknowledge memory port. Each request carries the address and the index of the register that the word belongs to.

Registers always fill the block in rising order, whatever the direction. The lowest-numbered selected register gets the lowest address. Each following register gets the next word up. The mode decides only where the block starts and where the base ends up.

The common stack disciplines map onto the four modes:
- A pop from a full-descending stack uses increment-after, and the matching push uses decrement-before.
- A pop from an empty-descending stack uses increment-before.
- A pop from a full-ascending stack uses decrement-after.
- A pop from an empty-ascending stack uses decrement-before.

When the last word is acknowledged, the unit pulses done. If writeback was requested, it also presents the updated base.

Top module: `blkxfer_seq`

## Requirements
- R1: The first address depends on `mode_i` (encoding 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before) and on n, the number of set bits in `mask_i`:
  - mode 0: base
  - mode 1: base+4
  - mode 2: base−4n+4
  - mode 3: base−4n
- R2: Exactly n accesses are issued for a transfer, at addresses that rise by 4 from one access to the next.
- R3: `mem_reg_o` is the index of the next set bit of the mask, taken from bit 0 upward, so the lowest-numbered register uses the lowest address in every mode.
- R4: When the writeback flag was set, `wb_valid_o` pulses together with `done_o`, and `wb_addr_o` then equals base+4n for modes 0 and 1, or base−4n for modes 2 and 3. When the flag was clear, `wb_valid_o` stays low.
- R5: While a request is not acknowledged, it stays up with its address and register index unchanged. The next access starts only after the current one is acknowledged.
- R6: `done_o` is a one-cycle pulse in the cycle after the final acknowledge, and no request is up in that cycle.
- R7: An empty mask completes with `done_o` in the cycle after start. No access is issued, and `wb_addr_o` equals the unchanged base.
- R8: A start raised while a transfer is in progress has no effect on the addresses, indices or count of that transfer.
- R9: `mem_we_o` is 1 for a store (`load_i`=0) and 0 for a load (`load_i`=1). It is held for every access of the transfer.
- R10: After reset there is no request, no done pulse, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (sampled while idle) |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Selected registers, bit i = register i |
| mode_i | input | 2 | Addressing mode (see R1) |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_i | input | 1 | Request base writeback |
| busy_o | output | 1 | Transfer in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word address of the access |
| mem_reg_o | output | 4 | Register index of the access |
| mem_ack_i | input | 1 | Memory acknowledge |
| done_o | output | 1 | Transfer complete pulse |
| wb_valid_o | output | 1 | Writeback base valid pulse |
| wb_addr_o | output | 32 | Updated base value |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 16-register mask and a 4-byte word. With these values, the full mask takes the span to 64 bytes. Random bases reach the wraparound of the 32-bit address when a decrement mode starts near zero. Acknowledge delays are random, which exercises holding a request across stalls. A start is injected mid-transfer with a full mask and an inverted base; this makes any leak into the running transfer visible in the addresses.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int BX_ADDR_W     = 32;
    localparam int BX_NREG       = 16;
    localparam int BX_WORD_BYTES = 4;

    typedef enum logic [1:0] {
        MODE_UP_POST   = 2'b00,
        MODE_UP_PRE    = 2'b01,
        MODE_DOWN_POST = 2'b10,
        MODE_DOWN_PRE  = 2'b11
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } state_e;

    function automatic logic mode_goes_down(mode_e m);
        return (m == MODE_DOWN_POST) || (m == MODE_DOWN_PRE);
    endfunction

    function automatic logic mode_is_pre(mode_e m);
        return (m == MODE_UP_PRE) || (m == MODE_DOWN_PRE);
    endfunction

endpackage

// File: rtl/blkxfer_span.sv
module blkxfer_span
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W     = BX_ADDR_W,
    parameter int NREG       = BX_NREG,
    parameter int WORD_BYTES = BX_WORD_BYTES
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   mask_i,
    input  mode_e             mode_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] final_o
);
    localparam int                CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CNT_W'(mask_i[i]);
        end
    end

    assign span = ADDR_W'(count) * STEP;

    always_comb begin
        if (mode_goes_down(mode_i)) begin
            low     = base_i - span;
            final_o = base_i - span;
        end else begin
            low     = base_i;
            final_o = base_i + span;
        end
        // "pre" going up skips the base word; "post" going down ends on it
        if (mode_goes_down(mode_i) != mode_is_pre(mode_i)) begin
            first_o = low + STEP;
        end else begin
            first_o = low;
        end
    end

endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [NREG-1:0]  rest_o
);
    logic [NREG-1:0] iso;

    for (genvar g = 0; g < NREG; g++) begin : g_iso
        if (g == 0) begin : g_lsb
            assign iso[g] = mask_i[0];
        end else begin : g_upper
            assign iso[g] = mask_i[g] & ~(|mask_i[g-1:0]);
        end
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (iso[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

    assign rest_o = mask_i & ~iso;

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W     = BX_ADDR_W,
    parameter int NREG       = BX_NREG,
    parameter int WORD_BYTES = BX_WORD_BYTES,
    localparam int IDX_W     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   mask_i,
    input  logic [1:0]        mode_i,
    input  logic              load_i,
    input  logic              wb_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [IDX_W-1:0]  mem_reg_o,
    input  logic              mem_ack_i,
    output logic              done_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    state_e            state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NREG-1:0]   left_q;
    logic              we_q;
    logic              wb_q;
    logic [ADDR_W-1:0] final_q;
    logic              done_q;
    logic              wbv_q;
    logic [ADDR_W-1:0] wbaddr_q;

    logic [ADDR_W-1:0] first_w;
    logic [ADDR_W-1:0] final_w;
    logic [NREG-1:0]   rest_w;
    logic [IDX_W-1:0]  idx_w;

    blkxfer_span #(
        .ADDR_W    (ADDR_W),
        .NREG      (NREG),
        .WORD_BYTES(WORD_BYTES)
    ) u_span (
        .base_i (base_i),
        .mask_i (mask_i),
        .mode_i (mode_e'(mode_i)),
        .first_o(first_w),
        .final_o(final_w)
    );

    blkxfer_pick #(
        .NREG (NREG),
        .IDX_W(IDX_W)
    ) u_pick (
        .mask_i(left_q),
        .idx_o (idx_w),
        .rest_o(rest_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            left_q   <= '0;
            we_q     <= 1'b0;
            wb_q     <= 1'b0;
            final_q  <= '0;
            done_q   <= 1'b0;
            wbv_q    <= 1'b0;
            wbaddr_q <= '0;
        end else begin
            done_q <= 1'b0;
            wbv_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (mask_i == '0) begin
                            done_q   <= 1'b1;
                            wbv_q    <= wb_i;
                            wbaddr_q <= base_i;
                        end else begin
                            state_q <= ST_MOVE;
                            addr_q  <= first_w;
                            left_q  <= mask_i;
                            we_q    <= ~load_i;
                            wb_q    <= wb_i;
                            final_q <= final_w;
                        end
                    end
                end
                ST_MOVE: begin
                    if (mem_ack_i) begin
                        left_q <= rest_w;
                        addr_q <= addr_q + STEP;
                        if (rest_w == '0) begin
                            state_q  <= ST_IDLE;
                            done_q   <= 1'b1;
                            wbv_q    <= wb_q;
                            wbaddr_q <= final_q;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (state_q == ST_MOVE);
    assign mem_req_o  = (state_q == ST_MOVE);
    assign mem_we_o   = we_q;
    assign mem_addr_o = addr_q;
    assign mem_reg_o  = idx_w;
    assign done_o     = done_q;
    assign wb_valid_o = wbv_q;
    assign wb_addr_o  = wbaddr_q;

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 4,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [IDX_W-1:0]  mem_reg_o,
    input logic              mem_ack_i,
    input logic              done_o,
    input logic              wb_valid_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_reg_o)));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + STEP)));

    p_ascend_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || (mem_reg_o > $past(mem_reg_o))));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!mem_req_o && !busy_o));

    p_wb_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> done_o);

    p_we_held_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && $past(mem_req_o)) |-> $stable(mem_we_o));

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req_o && !done_o && !busy_o));

endmodule

bind blkxfer_seq blkxfer_seq_chk #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .mem_reg_o (mem_reg_o),
    .mem_ack_i (mem_ack_i),
    .done_o    (done_o),
    .wb_valid_o(wb_valid_o)
);

// File: tb/blkxfer_seq_test.sv
module blkxfer_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] base_i;
    logic [15:0] mask_i;
    logic [1:0]  mode_i;
    logic        load_i;
    logic        wb_i;
    logic        busy_o;
    logic        mem_req_o;
    logic        mem_we_o;
    logic [31:0] mem_addr_o;
    logic [3:0]  mem_reg_o;
    logic        mem_ack_i;
    logic        done_o;
    logic        wb_valid_o;
    logic [31:0] wb_addr_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    blkxfer_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
        .mode_i(mode_i), .load_i(load_i), .wb_i(wb_i), .busy_o(busy_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_reg_o(mem_reg_o), .mem_ack_i(mem_ack_i), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
        logic [31:0] s = 32'(popc(m)) * 32'd4;
        case (md)
            2'd0: return b;
            2'd1: return b + 32'd4;
            2'd2: return b - s + 32'd4;
            default: return b - s;
        endcase
    endfunction

    function automatic logic [31:0] exp_final(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
        logic [31:0] s = 32'(popc(m)) * 32'd4;
        return md[1] ? b - s : b + s;
    endfunction

    function automatic logic [3:0] lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return 4'(i);
        return 4'd0;
    endfunction

    task automatic run_xfer(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                            input logic ld, input logic wb, input int maxd, input bit poke);
        logic [15:0] rem = m;
        logic [31:0] ea  = exp_first(b, m, md);
        int n = popc(m);
        int got = 0;
        int cyc = 0;
        int hold;
        bit fin = 0;
        bit poked = 0;
        bit last_acked = 0;
        @(negedge clk);
        base_i = b; mask_i = m; mode_i = md; load_i = ld; wb_i = wb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        hold = $urandom_range(0, maxd);
        while (!fin && cyc < 400) begin
            mem_ack_i = 1'b0;
            start_i   = 1'b0;
            if (done_o) begin
                fin = 1;
                check(got == n, "R2 access count", 32'(got), 32'(n));
                if (wb) begin
                    check(wb_valid_o == 1'b1, "R4 wb_valid", 32'(wb_valid_o), 32'd1);
                    check(wb_addr_o == (n == 0 ? b : exp_final(b, m, md)),
                          n == 0 ? "R7 base unchanged" : "R4 wb_addr", wb_addr_o,
                          n == 0 ? b : exp_final(b, m, md));
                end else begin
                    check(wb_valid_o == 1'b0, "R4 no wb_valid", 32'(wb_valid_o), 32'd0);
                end
                if (n == 0) check(cyc == 0, "R7 immediate done", 32'(cyc), 32'd0);
            end else begin
                if (last_acked) check(1'b0, "R6 done after final ack", 32'(done_o), 32'd1);
                if (mem_req_o) begin
                    if (n == 0) check(1'b0, "R7 no access on empty mask", 32'(mem_req_o), 32'd0);
                    if (poke && !poked) begin
                        poked = 1; start_i = 1'b1; base_i = ~b; mask_i = 16'hFFFF; mode_i = ~md;
                    end
                    if (hold > 0) begin
                        hold--;
                    end else begin
                        check(mem_addr_o == ea, md == exp_first(b, m, md) ? "R1" : (got == 0 ? "R1 first addr" : "R2 addr step"),
                              mem_addr_o, ea);
                        check(mem_reg_o == lowest(rem), poke ? "R8 index unaffected" : "R3 reg index",
                              32'(mem_reg_o), 32'(lowest(rem)));
                        check(mem_we_o == ~ld, "R9 write select", 32'(mem_we_o), 32'(~ld));
                        mem_ack_i = 1'b1;
                        rem = rem & (rem - 16'd1);
                        ea  = ea + 32'd4;
                        got++;
                        hold = $urandom_range(0, maxd);
                        if (got == n) last_acked = 1;
                        @(negedge clk);
                        cyc++;
                        continue;
                    end
                end
            end
            if (!fin) begin
                @(negedge clk);
                cyc++;
            end
        end
        mem_ack_i = 1'b0;
        start_i   = 1'b0;
        if (!fin) check(1'b0, "R6 done never seen", 32'd0, 32'd1);
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single pulse", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R6 run did not complete actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        rst = 1'b1; start_i = 1'b0; base_i = '0; mask_i = '0; mode_i = '0;
        load_i = 1'b1; wb_i = 1'b0; mem_ack_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_req_o == 1'b0, "R10 req after reset", 32'(mem_req_o), 32'd0);
        check(done_o == 1'b0, "R10 done after reset", 32'(done_o), 32'd0);
        check(busy_o == 1'b0, "R10 busy after reset", 32'(busy_o), 32'd0);

        // R1 R2 R3 R4: three registers from 0x10 in every mode, writeback on
        for (int md = 0; md < 4; md++) run_xfer(32'h10, 16'h000E, 2'(md), 1'b1, 1'b1, 0, 1'b0);
        // R7: empty mask, with and without writeback
        run_xfer(32'h1234_5678, 16'h0000, 2'd3, 1'b1, 1'b1, 0, 1'b0);
        run_xfer(32'h40, 16'h0000, 2'd0, 1'b0, 1'b0, 0, 1'b0);
        // full mask and top bit only, across zero wraparound
        run_xfer(32'h0000_0020, 16'hFFFF, 2'd3, 1'b0, 1'b1, 2, 1'b0);
        run_xfer(32'hFFFF_FFFC, 16'h8000, 2'd1, 1'b1, 1'b1, 1, 1'b0);
        run_xfer(32'h0, 16'h0001, 2'd2, 1'b0, 1'b1, 0, 1'b0);
        // R8: start raised mid-transfer
        run_xfer(32'h100, 16'h0A50, 2'd0, 1'b1, 1'b1, 3, 1'b1);
        run_xfer(32'h200, 16'h8001, 2'd3, 1'b0, 1'b0, 2, 1'b1);
        // random mix, R9 load and store alternate
        for (int k = 0; k < 60; k++) begin
            run_xfer({$urandom()} & 32'hFFFF_FFFC, 16'($urandom()), 2'($urandom_range(0, 3)),
                     1'($urandom()), 1'($urandom()), $urandom_range(0, 3), (k % 7) == 3);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule